// File: doc/BRIEF.md
# Energy-proportional pulse output generator

This block turns three streams of signed per-sample power values (active, reactive and apparent) into pulse trains whose average rate follows the magnitude of each power. Each sample strobe adds the magnitude of each power, scaled by a programmable pulse-rate fraction, into a per-channel fractional accumulator. Every carry out of that accumulator requests one active-low pulse of fixed width. If a request arrives while a pulse is still running, it is queued and issued after a single high cycle.

Three output pins carry the results. `e1_n` always carries active-energy pulses. `e2` carries either an energy-sign level or apparent-energy pulses. `e3` carries reactive-energy pulses, a registered copy of an externally supplied power-fail flag, a registered copy of the voltage-sign input, or apparent-energy pulses. Each pulse channel is driven by one state machine with states IDLE (no pulse, no backlog), ACTIVE (pin held low while the width counter runs) and GAP (one high cycle before a queued pulse). The transitions are: IDLE→ACTIVE on a request; ACTIVE→ACTIVE while the width counter runs; ACTIVE→IDLE at the end of the width with no backlog; ACTIVE→GAP at the end of the width with backlog; and GAP→ACTIVE, which takes one request from the backlog.

Top module: `energy_pulse_gen`

## Requirements
- R1: After reset `e1_n` is 1, `e2` is 1 (sign mode shows positive) and `e3` is 1 (reactive mode, no pulse).
- R2: On each strobe, each channel adds |power| × `rate` to an accumulator of PWR_W-1+RATE_W fraction bits. Each carry past 1.0 yields exactly one pulse and keeps the remainder. For full-scale power (2^(PWR_W-1)), this gives `rate`/2^RATE_W pulses per sample.
- R3: Every pulse holds its pin low for exactly PW_BASE × DIV_K clock cycles.
- R4: A request that arrives while a pulse is running, or while others are queued, is never dropped as long as the backlog stays below 2^PEND_W. Each queued pulse starts after exactly one high cycle.
- R5: With `e2_sel`=0, `e2` is 1 when the latched active power is ≥ 0 and 0 when it is negative. The latch loads on a strobe only when every channel is IDLE and no request is waiting, so a pulse caused by that sample falls with its sign already shown.
- R6: With `e2_sel`=0, `e2` does not change while `e1_n` is low.
- R7: With `e2_sel`=1, `e2` carries the apparent-energy pulses (active low).
- R8: With `e3_sel`=2'b00, `e3` carries the reactive-energy pulses (active low).
- R9: With `e3_sel`=2'b01, `e3` equals `pfail` as sampled on the previous clock edge.
- R10: With `e3_sel`=2'b10, `e3` equals `v_pos` as sampled on the previous clock edge.
- R11: With `e3_sel`=2'b11, `e3` carries the apparent-energy pulses (active low).
- R12: A pulse caused by a strobe sampled at edge k drives its pin low from edge k+1 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Sample strobe, one cycle per sample |
| p_act | input | PWR_W | Signed active power |
| p_react | input | PWR_W | Signed reactive power |
| p_app | input | PWR_W | Signed apparent power (magnitude used) |
| rate | input | RATE_W | Pulses per full-scale sample, fraction of 2^RATE_W |
| e2_sel | input | 1 | 0: sign level on e2, 1: apparent pulses |
| e3_sel | input | 2 | 00 reactive, 01 power-fail, 10 voltage sign, 11 apparent |
| pfail | input | 1 | Power-fail monitor level from outside |
| v_pos | input | 1 | Voltage channel sign (1 = positive) |
| e1_n | output | 1 | Active-energy pulses, active low |
| e2 | output | 1 | Sign level or apparent pulses |
| e3 | output | 1 | Reactive pulses, level, or apparent pulses |

## Verification
Two events can land in the same cycle. The first is a new carry request arriving while a pulse is still ACTIVE, which must go into the backlog instead of being lost. The second is a sample strobe arriving while a pulse is running, which must leave the sign latch untouched. The bench provokes both by sending a burst of back-to-back full-scale samples at the highest rate, so that requests pile up behind pulses of 8 cycles. It judges the result by comparing the number of falling edges after the pins settle with a model accumulator, by timing every low period, and by confirming that `e2` never moves during a pulse.

// File: rtl/ep_pkg.sv
package ep_pkg;

    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_ACTIVE = 2'd1,
        PS_GAP    = 2'd2
    } pulse_state_t;

    typedef enum logic [1:0] {
        E3_REACT = 2'b00,
        E3_PFAIL = 2'b01,
        E3_VSIGN = 2'b10,
        E3_APPAR = 2'b11
    } e3_mode_t;

    localparam int NCH      = 3;
    localparam int CH_ACT   = 0;
    localparam int CH_REACT = 1;
    localparam int CH_APP   = 2;

endpackage

// File: rtl/ep_accum.sv
module ep_accum #(
    parameter int PWR_W  = 24,
    parameter int RATE_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic signed [PWR_W-1:0] pwr,
    input  logic [RATE_W-1:0]       rate,
    output logic                    due
);
    localparam int FR = PWR_W - 1 + RATE_W;

    logic [PWR_W-1:0] mag;
    logic [FR-1:0]    prod;
    logic [FR-1:0]    acc_q;
    logic [FR:0]      sum;

    always_comb begin
        mag  = pwr[PWR_W-1] ? PWR_W'(-pwr) : PWR_W'(pwr);
        prod = FR'(mag) * FR'(rate);
        sum  = {1'b0, acc_q} + {1'b0, prod};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            due   <= 1'b0;
        end else if (smp_vld) begin
            acc_q <= sum[FR-1:0];
            due   <= sum[FR];
        end else begin
            due   <= 1'b0;
        end
    end

endmodule

// File: rtl/ep_pulser.sv
module ep_pulser
    import ep_pkg::*;
#(
    parameter int PW_CYC = 1024,
    parameter int PEND_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic due,
    output logic pulse_n,
    output logic idle
);
    localparam int CW = $clog2(PW_CYC + 1);

    pulse_state_t      state_q, state_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [PEND_W-1:0] pend_q, pend_d;
    logic              last, inc, dec;

    always_comb begin
        last    = (cnt_q == CW'(PW_CYC - 1));
        state_d = state_q;
        unique case (state_q)
            PS_IDLE:   if (due) state_d = PS_ACTIVE;
            PS_ACTIVE: if (last) state_d = ((pend_q != '0) || due) ? PS_GAP : PS_IDLE;
            PS_GAP:    state_d = PS_ACTIVE;
            default:   state_d = PS_IDLE;
        endcase
    end

    always_comb begin
        inc = due && (state_q != PS_IDLE) && !(&pend_q);
        dec = (state_q == PS_GAP);
        unique case ({inc, dec})
            2'b10:   pend_d = pend_q + 1'b1;
            2'b01:   pend_d = pend_q - 1'b1;
            default: pend_d = pend_q;
        endcase
        cnt_d = ((state_q == PS_ACTIVE) && (state_d == PS_ACTIVE)) ? cnt_q + 1'b1 : '0;
        idle  = (state_q == PS_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            cnt_q   <= '0;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_n <= 1'b1;
        else        pulse_n <= (state_d != PS_ACTIVE);
    end

endmodule

// File: rtl/ep_outsel.sv
module ep_outsel
    import ep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_vld,
    input  logic       act_neg,
    input  logic       all_idle,
    input  logic       any_due,
    input  logic       react_n,
    input  logic       app_n,
    input  logic       e2_sel,
    input  logic [1:0] e3_sel,
    input  logic       pfail,
    input  logic       v_pos,
    output logic       e2,
    output logic       e3
);
    logic sign_q, pf_q, vs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sign_q <= 1'b1;
            pf_q   <= 1'b0;
            vs_q   <= 1'b0;
        end else begin
            pf_q <= pfail;
            vs_q <= v_pos;
            if (smp_vld && all_idle && !any_due) sign_q <= !act_neg;
        end
    end

    always_comb begin
        e2 = e2_sel ? app_n : sign_q;
        unique case (e3_mode_t'(e3_sel))
            E3_REACT: e3 = react_n;
            E3_PFAIL: e3 = pf_q;
            E3_VSIGN: e3 = vs_q;
            E3_APPAR: e3 = app_n;
            default:  e3 = 1'b1;
        endcase
    end

endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen
    import ep_pkg::*;
#(
    parameter int PWR_W   = 24,
    parameter int RATE_W  = 16,
    parameter int PW_BASE = 1024,
    parameter int DIV_K   = 1,
    parameter int PEND_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic signed [PWR_W-1:0] p_act,
    input  logic signed [PWR_W-1:0] p_react,
    input  logic signed [PWR_W-1:0] p_app,
    input  logic [RATE_W-1:0]       rate,
    input  logic                    e2_sel,
    input  logic [1:0]              e3_sel,
    input  logic                    pfail,
    input  logic                    v_pos,
    output logic                    e1_n,
    output logic                    e2,
    output logic                    e3
);
    localparam int PW_CYC = PW_BASE * DIV_K;

    logic signed [PWR_W-1:0] pwr_ch [NCH];
    logic [NCH-1:0]          due_ch;
    logic [NCH-1:0]          pulse_ch_n;
    logic [NCH-1:0]          idle_ch;

    always_comb begin
        pwr_ch[CH_ACT]   = p_act;
        pwr_ch[CH_REACT] = p_react;
        pwr_ch[CH_APP]   = p_app;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ep_accum #(
            .PWR_W (PWR_W),
            .RATE_W(RATE_W)
        ) u_accum (
            .clk    (clk),
            .rst_n  (rst_n),
            .smp_vld(smp_vld),
            .pwr    (pwr_ch[g]),
            .rate   (rate),
            .due    (due_ch[g])
        );

        ep_pulser #(
            .PW_CYC(PW_CYC),
            .PEND_W(PEND_W)
        ) u_pulser (
            .clk    (clk),
            .rst_n  (rst_n),
            .due    (due_ch[g]),
            .pulse_n(pulse_ch_n[g]),
            .idle   (idle_ch[g])
        );
    end

    ep_outsel u_outsel (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .act_neg (p_act[PWR_W-1]),
        .all_idle(&idle_ch),
        .any_due (|due_ch),
        .react_n (pulse_ch_n[CH_REACT]),
        .app_n   (pulse_ch_n[CH_APP]),
        .e2_sel  (e2_sel),
        .e3_sel  (e3_sel),
        .pfail   (pfail),
        .v_pos   (v_pos),
        .e2      (e2),
        .e3      (e3)
    );

    assign e1_n = pulse_ch_n[CH_ACT];

endmodule

// File: rtl/ep_checks.sv
module ep_checks #(
    parameter int PW_CYC = 1024
) (
    input logic       clk,
    input logic       rst_n,
    input logic       e1_n,
    input logic       e2,
    input logic       e3,
    input logic       e2_sel,
    input logic [1:0] e3_sel,
    input logic       pfail,
    input logic       v_pos
);
    localparam int CW = $clog2(PW_CYC + 2) + 1;

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 low_cnt <= '0;
        else if (e1_n)              low_cnt <= '0;
        else if (!(&low_cnt))       low_cnt <= low_cnt + 1'b1;
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e1_n) |-> (low_cnt == CW'(PW_CYC))); // R3

    AST_SIGN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!e1_n && !$past(e1_n) && !e2_sel && !$past(e2_sel)) |-> (e2 == $past(e2))); // R6

    AST_PFAIL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (e3_sel == 2'b01 && $past(e3_sel) == 2'b01) |-> (e3 == $past(pfail))); // R9

    AST_VSIGN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (e3_sel == 2'b10 && $past(e3_sel) == 2'b10) |-> (e3 == $past(v_pos))); // R10

endmodule

bind energy_pulse_gen ep_checks #(.PW_CYC(PW_CYC)) u_ep_checks (
    .clk   (clk),
    .rst_n (rst_n),
    .e1_n  (e1_n),
    .e2    (e2),
    .e3    (e3),
    .e2_sel(e2_sel),
    .e3_sel(e3_sel),
    .pfail (pfail),
    .v_pos (v_pos)
);

// File: tb/energy_pulse_gen_bench.sv
`timescale 1ns/1ps
module energy_pulse_gen_bench;
    localparam int PWR_W  = 24;
    localparam int RATE_W = 16;
    localparam int PW     = 8;
    localparam longint FULL = 64'd1 << (PWR_W - 1 + RATE_W);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic signed [PWR_W-1:0] p_act = '0, p_react = '0, p_app = '0;
    logic [RATE_W-1:0] rate = '0;
    logic e2_sel = 1'b0;
    logic [1:0] e3_sel = 2'b00;
    logic pfail = 1'b0, v_pos = 1'b0;
    logic e1_n, e2, e3;

    int n_chk = 0, n_fail = 0;
    int n_e1 = 0, n_e2 = 0, n_e3 = 0;
    int n_sign_chk = 0, n_sign_bad = 0, n_glitch = 0;
    int low_len = 0;
    longint acc_a = 0, acc_r = 0, acc_p = 0;
    int exp_a = 0, exp_r = 0, exp_p = 0;
    bit chk_sign = 1'b0, exp_sign = 1'b1, done = 1'b0;
    logic prev_e1 = 1'b1, prev_e2 = 1'b1, prev_e3 = 1'b1;

    energy_pulse_gen #(
        .PWR_W(PWR_W), .RATE_W(RATE_W), .PW_BASE(4), .DIV_K(2), .PEND_W(4)
    ) u_energy_pulse_gen (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
        .p_act(p_act), .p_react(p_react), .p_app(p_app), .rate(rate),
        .e2_sel(e2_sel), .e3_sel(e3_sel), .pfail(pfail), .v_pos(v_pos),
        .e1_n(e1_n), .e2(e2), .e3(e3)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_step(ref longint acc, input int p, input int r);
        longint mag;
        mag = (p < 0) ? -longint'(p) : longint'(p);
        acc = acc + mag * longint'(r);
        if (acc >= FULL) begin
            acc = acc - FULL;
            return 1;
        end
        return 0;
    endfunction

    task automatic send(input int a, input int r, input int p);
        @(negedge clk);
        smp_vld = 1'b1;
        p_act = PWR_W'(a); p_react = PWR_W'(r); p_app = PWR_W'(p);
        exp_a += model_step(acc_a, a, int'(rate));
        exp_r += model_step(acc_r, r, int'(rate));
        exp_p += model_step(acc_p, p, int'(rate));
        exp_sign = (a >= 0);
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    function automatic int rnd_pwr();
        return int'($urandom_range(0, (1 << PWR_W) - 1)) - (1 << (PWR_W - 1));
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_e1 && !e1_n) begin
                n_e1++;
                if (chk_sign) begin
                    n_sign_chk++;
                    if (e2 !== exp_sign) n_sign_bad++;
                end
            end
            if (!e1_n) low_len++;
            else begin
                if (!prev_e1) check(low_len == PW, "R3 e1 low width", low_len, PW);
                low_len = 0;
            end
            if (!e1_n && !prev_e1 && !e2_sel && (e2 !== prev_e2)) n_glitch++;
            if (prev_e2 && !e2) n_e2++;
            if (prev_e3 && !e3) n_e3++;
            prev_e1 = e1_n; prev_e2 = e2; prev_e3 = e3;
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            finish_run();
        end
    end

    initial begin
        int s1, s2, s3, e1b, e2b, e3b;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(e1_n == 1'b1, "R1 e1_n after reset", int'(e1_n), 1);
        check(e2 == 1'b1, "R1 e2 after reset", int'(e2), 1);
        check(e3 == 1'b1, "R1 e3 after reset", int'(e3), 1);

        // R12 latency, with negative sign (R5)
        rate = 16'hFFFF;
        send(-(1 << 23), 0, 0);
        check(e1_n == 1'b1, "R2 no pulse below 1.0", int'(e1_n), 1);
        send(-(1 << 23), 0, 0);
        check(e1_n == 1'b1, "R12 e1_n high one edge after strobe", int'(e1_n), 1);
        @(negedge clk);
        check(e1_n == 1'b0, "R12 e1_n low two edges after strobe", int'(e1_n), 0);
        check(e2 == 1'b0, "R5 sign negative at fall", int'(e2), 0);
        repeat (20) @(negedge clk);

        // spaced random samples: E1 active, E3 reactive, E2 sign
        chk_sign = 1'b1;
        s1 = n_e1; s3 = n_e3; e1b = exp_a; e3b = exp_r;
        for (int i = 0; i < 80; i++) begin
            rate = RATE_W'($urandom);
            send(rnd_pwr(), rnd_pwr(), rnd_pwr());
            repeat (PW + 4) @(negedge clk);
        end
        repeat (30) @(negedge clk);
        chk_sign = 1'b0;
        check(n_e1 - s1 == exp_a - e1b, "R2 active pulse count", n_e1 - s1, exp_a - e1b);
        check(n_e3 - s3 == exp_r - e3b, "R8 reactive pulse count on e3", n_e3 - s3, exp_r - e3b);
        check(n_sign_chk > 10, "R5 sign samples taken", n_sign_chk, 11);
        check(n_sign_bad == 0, "R5 sign at e1 fall", n_sign_bad, 0);

        // burst: requests while pulses run
        rate = 16'hFFFF;
        s1 = n_e1; e1b = exp_a;
        for (int i = 0; i < 8; i++) send(((i % 2) == 0) ? -(1 << 23) : (1 << 23) - 1, 0, 0);
        check(e1_n == 1'b0, "R4 pulse running during burst", int'(e1_n), 0);
        repeat (200) @(negedge clk);
        check(n_e1 - s1 == exp_a - e1b, "R4 no pulse lost in burst", n_e1 - s1, exp_a - e1b);
        check(exp_a - e1b >= 6, "R4 burst built a backlog", exp_a - e1b, 6);
        check(n_glitch == 0, "R6 e2 held while e1_n low", n_glitch, 0);

        // apparent pulses on e2 and e3
        e2_sel = 1'b1; e3_sel = 2'b11;
        repeat (4) @(negedge clk);
        s2 = n_e2; s3 = n_e3; e2b = exp_p;
        for (int i = 0; i < 60; i++) begin
            rate = RATE_W'($urandom_range(16'h4000, 16'hFFFF));
            send(rnd_pwr(), rnd_pwr(), rnd_pwr());
            repeat (PW + 4) @(negedge clk);
        end
        repeat (30) @(negedge clk);
        check(n_e2 - s2 == exp_p - e2b, "R7 apparent pulse count on e2", n_e2 - s2, exp_p - e2b);
        check(n_e3 - s3 == exp_p - e2b, "R11 apparent pulse count on e3", n_e3 - s3, exp_p - e2b);

        // level modes on e3
        e3_sel = 2'b01;
        for (int i = 0; i < 12; i++) begin
            pfail = 1'($urandom);
            @(negedge clk);
            check(e3 == pfail, "R9 e3 follows pfail", int'(e3), int'(pfail));
        end
        e3_sel = 2'b10;
        for (int i = 0; i < 12; i++) begin
            v_pos = 1'($urandom);
            @(negedge clk);
            check(e3 == v_pos, "R10 e3 follows v_pos", int'(e3), int'(v_pos));
        end

        done = 1'b1;
        finish_run();
    end

endmodule